// File: doc/BRIEF.md
# Reference-Ratio Frequency Lock Detector

This block judges whether a recovered clock is frequency locked to a local reference clock. It works out by itself whether the reference runs at one sixteenth, one thirty-second or one hundred twenty-eighth of the recovered rate. Once it knows the ratio, it keeps comparing the reference against the recovered clock divided by that ratio. When the two disagree by more than a set number of counts, it drives an active-low loss-of-lock alarm.

The reference domain only marks off gate windows of a fixed number of reference cycles. A counter in the recovered-clock domain measures each window. Every completed window yields a ratio code and a lock verdict. If the reference stops, the measurement counter times out and the block reports that no valid reference is present.

While the block is out of lock, it issues a reacquire pulse at a fixed window interval. An active-low lock-to-reference request suppresses those pulses. The request also drives one of two outputs for the loop: select the reference when a valid reference is present, or hold the frequency word when it is not. In a typical system the loss-of-signal alarm feeds the request, so losing data yields a steady output clock.

Top module: `fld_lock_detect`

## Requirements
- R1: `ratio_code` reports the ratio whose expected window count GATE*R (R = 16, 32 or 128) lies within ±10% of the measured recovered-clock count: 2'b01 for 16, 2'b10 for 32, 2'b11 for 128. When no candidate is that close, it reports 2'b00 (no valid reference).
- R2: Ratio detection repeats every window with no configuration input, so a change of reference frequency shows up in `ratio_code` after the next complete window.
- R3: After a window, `lol_n` is high only if a ratio was detected and the measured count is within ±TOL of GATE*R. Otherwise it is low.
- R4: During reset and after it, `lol_n` is low, `ratio_code` is 2'b00, and `reacq`, `sel_ref` and `hold_freq` are low. The first window after reset is discarded, so `lol_n` stays low until one full window has been evaluated.
- R5: If no window ends within GATE*128*11/10+1 recovered cycles, the block treats the reference as missing: `ratio_code` becomes 2'b00 and `lol_n` goes low.
- R6: While out of lock and with the request released, `reacq` pulses high for one recovered-clock cycle once every REACQ_WIN evaluated windows.
- R7: While `ltr_n` is low, `reacq` stays low.
- R8: With `ltr_n` low and a valid ratio detected, `sel_ref` is high and `hold_freq` is low.
- R9: With `ltr_n` low and no valid ratio, `hold_freq` is high and `sel_ref` is low. With `ltr_n` high, both are low.
- R10: `lol_n` and `ratio_code` change only in the cycle after a window ends or the measurement times out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rec_clk | input | 1 | Recovered clock; all outputs are in this domain |
| ref_clk | input | 1 | Local reference clock |
| rst | input | 1 | Synchronous active-high reset, in the rec_clk domain |
| ltr_n | input | 1 | Lock-to-reference request, active low, asynchronous |
| ratio_code | output | 2 | Detected ratio: 00 none, 01 x16, 10 x32, 11 x128 |
| lol_n | output | 1 | Loss-of-lock alarm, active low |
| reacq | output | 1 | One-cycle reacquire attempt pulse |
| sel_ref | output | 1 | Force the loop onto the reference |
| hold_freq | output | 1 | Freeze the loop frequency word |

## Verification
The bench builds the block with GATE=32, TOL=2 and REACQ_WIN=4. A window then lasts 512 to 4096 recovered cycles, and the missing-reference timeout fires after about 4.5k cycles. This makes many windows, both ratio changes and a stopped reference fit easily in the run. The short reacquire interval lets the bench count several pulses in a few windows. The bench offsets the reference period in steps of one count per window, so the ±TOL lock edge and the ±10% ratio edge can be placed exactly.

// File: rtl/fld_pkg.sv
package fld_pkg;
  typedef enum logic [1:0] {
    RC_NONE = 2'b00,
    RC_X16  = 2'b01,
    RC_X32  = 2'b10,
    RC_X128 = 2'b11
  } ratio_e;
endpackage

// File: rtl/fld_ref_gate.sv
// Reference-domain gate: flips a toggle every GATE reference cycles.
module fld_ref_gate #(
  parameter int GATE = 4096
) (
  input  logic ref_clk,
  input  logic rst_in,
  output logic gate_tgl
);
  localparam int GW = (GATE > 2) ? $clog2(GATE) : 1;

  logic [1:0]    rst_pipe;
  logic [GW-1:0] cnt;

  always_ff @(posedge ref_clk) rst_pipe <= {rst_pipe[0], rst_in};

  always_ff @(posedge ref_clk) begin
    if (rst_pipe[1]) begin
      cnt      <= '0;
      gate_tgl <= 1'b0;
    end else if (cnt == GW'(GATE - 1)) begin
      cnt      <= '0;
      gate_tgl <= ~gate_tgl;
    end else begin
      cnt <= cnt + GW'(1);
    end
  end
endmodule

// File: rtl/fld_tgl_sync.sv
// Two-flop synchroniser plus edge detect for the gate toggle.
module fld_tgl_sync (
  input  logic clk,
  input  logic rst,
  input  logic tgl_in,
  output logic edge_o
);
  logic [2:0] s;

  always_ff @(posedge clk) begin
    if (rst) s <= '0;
    else     s <= {s[1:0], tgl_in};
  end

  assign edge_o = s[2] ^ s[1];
endmodule

// File: rtl/fld_classify.sv
// Picks the candidate ratio whose expected count is within 10% of the measurement.
module fld_classify
  import fld_pkg::*;
#(
  parameter int GATE = 4096,
  parameter int CW   = 20
) (
  input  logic [CW-1:0] meas_i,
  output ratio_e        code_o,
  output int unsigned   exp_o
);
  localparam int unsigned RAT [3] = '{16, 32, 128};

  always_comb begin
    int unsigned m;
    m      = 32'(meas_i);
    code_o = RC_NONE;
    exp_o  = 0;
    for (int i = 0; i < 3; i++) begin
      if ((10 * m >= 9 * GATE * RAT[i]) && (10 * m <= 11 * GATE * RAT[i])) begin
        code_o = ratio_e'(2'(i + 1));
        exp_o  = GATE * RAT[i];
      end
    end
  end
endmodule

// File: rtl/fld_lock_detect.sv
module fld_lock_detect
  import fld_pkg::*;
#(
  parameter int GATE      = 4096,
  parameter int TOL       = 8,
  parameter int REACQ_WIN = 64
) (
  input  logic       rec_clk,
  input  logic       ref_clk,
  input  logic       rst,
  input  logic       ltr_n,
  output logic [1:0] ratio_code,
  output logic       lol_n,
  output logic       reacq,
  output logic       sel_ref,
  output logic       hold_freq
);
  localparam int CNT_MAX = (GATE * 128 * 11) / 10 + 1;
  localparam int CW      = $clog2(CNT_MAX + 2);
  localparam int RW      = (REACQ_WIN > 2) ? $clog2(REACQ_WIN) : 1;

  logic          gate_tgl, win_end, timeout, win_evt, primed, locked, req;
  logic [CW-1:0] cnt, meas;
  logic [RW-1:0] rq_cnt;
  logic [1:0]    ltr_s;
  ratio_e        code, ratio_q;
  int unsigned   exp_v;
  int            diff;

  fld_ref_gate #(.GATE(GATE)) u_gate (
    .ref_clk (ref_clk),
    .rst_in  (rst),
    .gate_tgl(gate_tgl)
  );

  fld_tgl_sync u_sync (
    .clk   (rec_clk),
    .rst   (rst),
    .tgl_in(gate_tgl),
    .edge_o(win_end)
  );

  assign meas = cnt + CW'(1);

  fld_classify #(.GATE(GATE), .CW(CW)) u_cls (
    .meas_i(meas),
    .code_o(code),
    .exp_o (exp_v)
  );

  assign timeout = (cnt == CW'(CNT_MAX));
  assign win_evt = win_end || timeout;

  always_comb begin
    diff   = int'(32'(meas)) - int'(exp_v);
    if (diff < 0) diff = -diff;
    locked = !timeout && (code != RC_NONE) && (diff <= TOL);
  end

  always_ff @(posedge rec_clk) begin
    if (rst) ltr_s <= 2'b11;
    else     ltr_s <= {ltr_s[0], ltr_n};
  end
  assign req = !ltr_s[1];

  always_ff @(posedge rec_clk) begin
    if (rst) begin
      cnt     <= '0;
      primed  <= 1'b0;
      ratio_q <= RC_NONE;
      lol_n   <= 1'b0;
      rq_cnt  <= '0;
      reacq   <= 1'b0;
    end else begin
      reacq <= 1'b0;
      if (win_evt) begin
        cnt    <= '0;
        primed <= 1'b1;
        if (primed || timeout) begin
          ratio_q <= timeout ? RC_NONE : code;
          lol_n   <= locked;
          if (!locked && !req) begin
            if (rq_cnt == RW'(REACQ_WIN - 1)) begin
              rq_cnt <= '0;
              reacq  <= 1'b1;
            end else begin
              rq_cnt <= rq_cnt + RW'(1);
            end
          end else begin
            rq_cnt <= '0;
          end
        end
      end else begin
        cnt <= cnt + CW'(1);
      end
    end
  end

  always_ff @(posedge rec_clk) begin
    if (rst) begin
      sel_ref   <= 1'b0;
      hold_freq <= 1'b0;
    end else begin
      sel_ref   <= req && (ratio_q != RC_NONE);
      hold_freq <= req && (ratio_q == RC_NONE);
    end
  end

  assign ratio_code = ratio_q;
endmodule

// File: rtl/fld_lock_detect_chk.sv
module fld_lock_detect_chk (
  input logic       rec_clk,
  input logic       rst,
  input logic [1:0] ratio_code,
  input logic       lol_n,
  input logic       reacq,
  input logic       sel_ref,
  input logic       hold_freq,
  input logic       win_evt
);
  AST_LOCK_NEEDS_RATIO: assert property (@(posedge rec_clk) disable iff (rst)
    lol_n |-> (ratio_code != 2'b00)); // R3
  AST_RESET_ALARM: assert property (@(posedge rec_clk) disable iff (rst)
    $past(rst) |-> (!lol_n && ratio_code == 2'b00)); // R4
  AST_REACQ_ONE_CYCLE: assert property (@(posedge rec_clk) disable iff (rst)
    reacq |=> !reacq); // R6
  AST_REACQ_OUT_OF_LOCK: assert property (@(posedge rec_clk) disable iff (rst)
    reacq |-> !lol_n); // R6
  AST_REACQ_NOT_FORCED: assert property (@(posedge rec_clk) disable iff (rst)
    reacq |-> !(sel_ref || hold_freq)); // R7
  AST_SEL_HOLD_EXCL: assert property (@(posedge rec_clk) disable iff (rst)
    !(sel_ref && hold_freq)); // R9
  AST_LOL_AT_WINDOW: assert property (@(posedge rec_clk) disable iff (rst)
    !$stable(lol_n) |-> $past(win_evt)); // R10
  AST_RATIO_AT_WINDOW: assert property (@(posedge rec_clk) disable iff (rst)
    !$stable(ratio_code) |-> $past(win_evt)); // R10
endmodule

bind fld_lock_detect fld_lock_detect_chk u_chk (
  .rec_clk   (rec_clk),
  .rst       (rst),
  .ratio_code(ratio_code),
  .lol_n     (lol_n),
  .reacq     (reacq),
  .sel_ref   (sel_ref),
  .hold_freq (hold_freq),
  .win_evt   (win_evt)
);

// File: tb/fld_lock_detect_tb.sv
`timescale 1ps/1ps
module fld_lock_detect_tb;
  localparam int GATE = 32;
  localparam int TOL  = 2;
  localparam int RWIN = 4;
  localparam int TMO  = (GATE * 128 * 11) / 10 + 1;

  logic rec_clk = 1'b0, ref_clk = 1'b0, rst = 1'b1, ltr_n = 1'b1;
  logic [1:0] ratio_code;
  logic lol_n, reacq, sel_ref, hold_freq;

  int  ref_half = 64000;
  bit  ref_run  = 1'b1;
  int  tests = 0, fails = 0, pulses = 0;

  fld_lock_detect #(.GATE(GATE), .TOL(TOL), .REACQ_WIN(RWIN)) u_dut (
    .rec_clk(rec_clk), .ref_clk(ref_clk), .rst(rst), .ltr_n(ltr_n),
    .ratio_code(ratio_code), .lol_n(lol_n), .reacq(reacq),
    .sel_ref(sel_ref), .hold_freq(hold_freq)
  );

  always #4000 rec_clk = ~rec_clk;
  always begin
    if (ref_run) #(ref_half) ref_clk = ~ref_clk;
    else         #8000;
  end
  always @(negedge rec_clk) if (reacq) pulses++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // ratio r, offset dev counts per window (each count = 250 ps of reference period)
  task automatic set_ref(input int r, input int dev);
    ref_half = (8000 * r + dev * 250) / 2;
  endtask

  task automatic settle();
    repeat (3 * GATE + 4) @(posedge ref_clk);
    repeat (8) @(negedge rec_clk);
  endtask

  function automatic int exp_code(input int r, input int dev);
    int m, e;
    m = GATE * r + dev;
    exp_code = 0;
    e = GATE * 16;  if (10 * m >= 9 * e && 10 * m <= 11 * e) exp_code = 1;
    e = GATE * 32;  if (10 * m >= 9 * e && 10 * m <= 11 * e) exp_code = 2;
    e = GATE * 128; if (10 * m >= 9 * e && 10 * m <= 11 * e) exp_code = 3;
  endfunction

  function automatic int exp_lock(input int r, input int dev);
    exp_lock = (exp_code(r, dev) != 0 && (dev <= TOL - 1) && (dev >= -(TOL - 1))) ? 1 : 0;
  endfunction

  task automatic check_cfg(input int r, input int dev, input string tag);
    set_ref(r, dev);
    settle();
    chk(int'(ratio_code) == exp_code(r, dev), {tag, " ratio R1"}, ratio_code, exp_code(r, dev));
    chk(int'(lol_n) == exp_lock(r, dev), {tag, " lock R3"}, lol_n, exp_lock(r, dev));
  endtask

  initial begin
    void'($urandom(32'd1234));
    set_ref(16, 0);
    repeat (100) @(negedge rec_clk);
    chk(lol_n == 1'b0 && ratio_code == 2'b00, "R4 reset alarm", {ratio_code, lol_n}, 0);
    chk(!reacq && !sel_ref && !hold_freq, "R4 reset outputs", {reacq, sel_ref, hold_freq}, 0);
    rst = 1'b0;
    repeat (768) @(negedge rec_clk);
    chk(lol_n == 1'b0, "R4 first window discarded", lol_n, 0);

    check_cfg(16, 0, "x16");
    check_cfg(32, 0, "R2 x32");
    check_cfg(128, 0, "R2 x128");
    check_cfg(64, 0, "x64 invalid");
    check_cfg(16, 8, "x16 off by 8");
    check_cfg(16, 25, "x16 5pc off");
    check_cfg(16, 102, "x16 20pc off");
    check_cfg(32, -1, "R3 lower edge");

    for (int i = 0; i < 10; i++) begin
      int r, dev;
      r = ($urandom % 2 == 0) ? 16 : 32;
      do dev = int'($urandom % 17) - 8; while (dev == 2 || dev == 3 || dev == -2 || dev == -3);
      check_cfg(r, dev, "random");
    end

    begin
      int p0;
      set_ref(16, 8);
      settle();
      p0 = pulses;
      repeat (16 * GATE) @(posedge ref_clk);
      chk(pulses - p0 >= 3 && pulses - p0 <= 5, "R6 reacq rate", pulses - p0, 4);
      ltr_n = 1'b0;
      repeat (6) @(negedge rec_clk);
      chk(sel_ref && !hold_freq, "R8 force ref", {sel_ref, hold_freq}, 2);
      p0 = pulses;
      repeat (12 * GATE) @(posedge ref_clk);
      chk(pulses == p0, "R7 reacq suppressed", pulses - p0, 0);
      chk(lol_n == 1'b0, "R7 still unlocked", lol_n, 0);
    end

    ref_run = 1'b0;
    repeat (2 * TMO + 100) @(negedge rec_clk);
    chk(ratio_code == 2'b00 && lol_n == 1'b0, "R5 missing ref", {ratio_code, lol_n}, 0);
    chk(hold_freq && !sel_ref, "R9 hold without ref", {sel_ref, hold_freq}, 1);
    ltr_n = 1'b1;
    repeat (6) @(negedge rec_clk);
    chk(!hold_freq && !sel_ref, "R9 released", {sel_ref, hold_freq}, 0);
    ref_run = 1'b1;
    check_cfg(16, 0, "R2 ref restored");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge rec_clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule